// File: doc/BRIEF.md
# Edge Interrupt Controller

This block watches sixteen external input lines and turns their edges into interrupt requests and event pulses. Line n can listen to bit n of any one of several input ports. A small select field per line picks the port. Each line has its own rising-edge enable, falling-edge enable, interrupt mask and event mask.

An enabled edge on an interrupt-unmasked line sets a sticky pending flag. The pending flag is gated by the mask to drive that line's request output, and it stays set until software writes a 1 to it. An enabled edge on an event-unmasked line gives a pulse of one clock cycle on the event output. The event path never touches the pending flag.

Software programs the block through a simple register bus. Writes are synchronous and reads are combinational. Each input passes through a two-flop synchronizer before edge detection.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `evt` are all 0.
- R2: Registers are word addressed. Addresses 0 to 3 hold the port selects, with line n's 4-bit field in the register at address n>>2, bits 4*(n&3)+3 down to 4*(n&3). Bits above the four fields read 0. Address 4 is the interrupt mask, 5 the event mask, 6 the rising enable, 7 the falling enable and 8 the pending register. In registers 4 to 8, bit n belongs to line n.
- R3: Line n sees only bit n of the port its select field names. Toggling bit n of any other port has no effect on that line.
- R4: With the rising enable set, a 0-to-1 change on the selected input gives `evt` high in the second cycle after the input is sampled. In the third cycle, the pending bit and `irq` are high.
- R5: The falling enable works the same way for 1-to-0 changes. With both enables set, both kinds of change trigger.
- R6: A line with neither enable set never pulses `evt` and never sets its pending bit.
- R7: `evt` pulses for exactly one cycle on a triggering edge when the event mask bit is 1, and stays low when it is 0. An edge on a line whose interrupt mask is 0 does not set the pending bit, even if the event pulse is produced.
- R8: `irq[n]` equals pending bit n ANDed with interrupt mask bit n. Clearing the mask lowers `irq` but leaves the pending bit set.
- R9: Writing 1 to a bit of the pending register clears that bit. Writing 0 leaves it unchanged.
- R10: If a triggering edge and a clear of the same line occur in the same cycle, the pending bit ends up set.
- R11: A select value of NUM_PORTS or more connects the line to a constant 0, so that line never triggers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | NUM_PORTS*NUM_LINES | Port inputs; port p, bit n at index p*NUM_LINES+n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` (combinational) |
| irq | output | NUM_LINES | Per-line interrupt request |
| evt | output | NUM_LINES | Per-line one-cycle event pulse |

## Verification
An input change driven before clock edge k reaches the synchronizer output at edge k+2. At that point the event pulse is visible, and the pending bit and `irq` follow at edge k+3. A register write becomes visible one edge after the strobe. The driver records each expected value together with the cycle count at which it is due: the event at +2, the request at +3, and register reads at +0. The monitor compares each record only in its own cycle, half a period after the edge. The clear-versus-edge collision is made to happen by issuing the clear write exactly two cycles after the input change.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   // register offsets that follow the block of port-select words
   localparam int OFS_IMASK = 0;
   localparam int OFS_EMASK = 1;
   localparam int OFS_RISE  = 2;
   localparam int OFS_FALL  = 3;
   localparam int OFS_PEND  = 4;
   localparam int NUM_CTRL_REGS = 5;

   typedef struct packed {
      logic rise;
      logic fall;
      logic imask;
      logic emask;
   } line_ctl_t;

endpackage

// File: rtl/eirq_regs.sv
module eirq_regs
   import eirq_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int SEL_W     = 4,
   parameter int FIELDS    = 4,
   parameter int REG_W     = 32,
   parameter int ADDR_W    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [REG_W-1:0]           wdata,
   input  logic [NUM_LINES-1:0]       pend,
   output logic [REG_W-1:0]           rdata,
   output logic [NUM_LINES*SEL_W-1:0] sel,
   output logic [NUM_LINES-1:0]       imask,
   output logic [NUM_LINES-1:0]       emask,
   output logic [NUM_LINES-1:0]       rise_en,
   output logic [NUM_LINES-1:0]       fall_en,
   output logic [NUM_LINES-1:0]       clr
);

   localparam int NSEL = (NUM_LINES + FIELDS - 1) / FIELDS;
   localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(NSEL + OFS_IMASK);
   localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(NSEL + OFS_EMASK);
   localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(NSEL + OFS_RISE);
   localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(NSEL + OFS_FALL);
   localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(NSEL + OFS_PEND);

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^wdata;

   // one select field per line, packed FIELDS to a word
   for (genvar n = 0; n < NUM_LINES; n++) begin : g_sel
      localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(n / FIELDS);
      localparam int LSB = (n % FIELDS) * SEL_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel[n*SEL_W +: SEL_W] <= '0;
         else if (wr_en && addr == A_WORD)
            sel[n*SEL_W +: SEL_W] <= wdata[LSB +: SEL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imask   <= '0;
         emask   <= '0;
         rise_en <= '0;
         fall_en <= '0;
      end else if (wr_en) begin
         if (addr == A_IMASK) imask   <= wdata[NUM_LINES-1:0];
         if (addr == A_EMASK) emask   <= wdata[NUM_LINES-1:0];
         if (addr == A_RISE)  rise_en <= wdata[NUM_LINES-1:0];
         if (addr == A_FALL)  fall_en <= wdata[NUM_LINES-1:0];
      end
   end

   assign clr = (wr_en && addr == A_PEND) ? wdata[NUM_LINES-1:0] : '0;

   always_comb begin
      rdata = '0;
      for (int n = 0; n < NUM_LINES; n++) begin
         if (addr == ADDR_W'(n / FIELDS))
            rdata[(n % FIELDS)*SEL_W +: SEL_W] = sel[n*SEL_W +: SEL_W];
      end
      if (addr == A_IMASK) rdata[NUM_LINES-1:0] = imask;
      if (addr == A_EMASK) rdata[NUM_LINES-1:0] = emask;
      if (addr == A_RISE)  rdata[NUM_LINES-1:0] = rise_en;
      if (addr == A_FALL)  rdata[NUM_LINES-1:0] = fall_en;
      if (addr == A_PEND)  rdata[NUM_LINES-1:0] = pend;
   end

endmodule

// File: rtl/eirq_line.sv
module eirq_line
   import eirq_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] src,
   input  logic [SEL_W-1:0]     sel,
   input  line_ctl_t            ctl,
   input  logic                 clr,
   output logic                 pend,
   output logic                 trig,
   output logic                 evt
);

   logic raw;
   logic sync_q;
   logic prev_q;

   // port select: out-of-range index yields a constant low input
   always_comb begin
      raw = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (sel == SEL_W'(p)) raw = src[p];
      end
   end

   if (SYNC_STAGES == 2) begin : g_sync2
      logic meta_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
         end else begin
            meta_q <= raw;
            sync_q <= meta_q;
         end
      end
   end else begin : g_syncn
      logic [SYNC_STAGES-2:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            sync_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[SYNC_STAGES-3:0], raw};
            sync_q  <= chain_q[SYNC_STAGES-2];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q;
   end

   assign trig = (ctl.rise & sync_q & ~prev_q) | (ctl.fall & ~sync_q & prev_q);
   assign evt  = trig & ctl.emask;

   // a new request wins over a clear arriving in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= (pend & ~clr) | (trig & ctl.imask);
   end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import eirq_pkg::*;
#(
   parameter int NUM_LINES   = 16,
   parameter int NUM_PORTS   = 4,
   parameter int SEL_W       = 4,
   parameter int FIELDS      = 4,
   parameter int REG_W       = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PORTS*NUM_LINES-1:0] pins_in,
   input  logic                           reg_wr,
   input  logic [ADDR_W-1:0]              reg_addr,
   input  logic [REG_W-1:0]               reg_wdata,
   output logic [REG_W-1:0]               reg_rdata,
   output logic [NUM_LINES-1:0]           irq,
   output logic [NUM_LINES-1:0]           evt
);

   localparam int NSEL = (NUM_LINES + FIELDS - 1) / FIELDS;

   if (FIELDS * SEL_W > REG_W) begin : g_err_fields
      $error("select fields do not fit one register word");
   end
   if (NUM_LINES > REG_W) begin : g_err_lines
      $error("line count exceeds register width");
   end
   if (NUM_PORTS > (1 << SEL_W)) begin : g_err_ports
      $error("select field too narrow for port count");
   end
   if (NSEL + NUM_CTRL_REGS > (1 << ADDR_W)) begin : g_err_addr
      $error("address width too small for register map");
   end
   if (SYNC_STAGES < 2) begin : g_err_sync
      $error("synchronizer needs at least two stages");
   end

   logic [NUM_LINES*SEL_W-1:0] sel_w;
   logic [NUM_LINES-1:0] imask_w, emask_w, rise_w, fall_w, clr_w, pend_w, trig_w;

   eirq_regs #(
      .NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .FIELDS(FIELDS),
      .REG_W(REG_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .pend(pend_w), .rdata(reg_rdata), .sel(sel_w),
      .imask(imask_w), .emask(emask_w), .rise_en(rise_w), .fall_en(fall_w),
      .clr(clr_w)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      logic [NUM_PORTS-1:0] src;
      line_ctl_t ctl;
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_src
         assign src[p] = pins_in[p*NUM_LINES + n];
      end
      assign ctl.rise  = rise_w[n];
      assign ctl.fall  = fall_w[n];
      assign ctl.imask = imask_w[n];
      assign ctl.emask = emask_w[n];

      eirq_line #(
         .NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
      ) u_line (
         .clk(clk), .rst_n(rst_n), .src(src), .sel(sel_w[n*SEL_W +: SEL_W]),
         .ctl(ctl), .clr(clr_w[n]), .pend(pend_w[n]), .trig(trig_w[n]),
         .evt(evt[n])
      );
   end

   assign irq = pend_w & imask_w;

endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
   parameter int NUM_LINES = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] pend,
   input logic [NUM_LINES-1:0] trig,
   input logic [NUM_LINES-1:0] clr,
   input logic [NUM_LINES-1:0] imask,
   input logic [NUM_LINES-1:0] emask,
   input logic [NUM_LINES-1:0] rise_en,
   input logic [NUM_LINES-1:0] fall_en,
   input logic [NUM_LINES-1:0] irq,
   input logic [NUM_LINES-1:0] evt
);

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pend == '0 && irq == '0 && evt == '0));

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         pend[i] && !clr[i] |=> pend[i]);
      p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
         clr[i] && !trig[i] |=> !pend[i]);
      p_race_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
         clr[i] && trig[i] && imask[i] |=> pend[i]);
      p_pend_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !pend[i] && !(trig[i] && imask[i]) |=> !pend[i]);
      p_evt_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |-> (emask[i] && trig[i]));
      p_trig_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
         trig[i] |-> (rise_en[i] || fall_en[i]));
   end

endmodule

bind edge_irq_ctrl eirq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .pend(pend_w), .trig(trig_w), .clr(clr_w),
   .imask(imask_w), .emask(emask_w), .rise_en(rise_w), .fall_en(fall_w),
   .irq(irq), .evt(evt)
);

// File: tb/edge_irq_ctrl_tb.sv
`timescale 1ns/1ps
module edge_irq_ctrl_tb;

   localparam int K_IRQ = 0;
   localparam int K_EVT = 1;
   localparam int K_REG = 2;

   typedef struct {
      int          due;
      int          kind;
      logic [3:0]  addr;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] pins = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] irq;
   logic [15:0] evt;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   item_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   edge_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .pins_in(pins), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .evt(evt)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_at(input int kind, input int dly, input logic [31:0] v,
                            input string tag);
      item_t it;
      it.due = cyc + dly; it.kind = kind; it.addr = reg_addr;
      it.exp = v; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] v, input string tag);
      reg_addr = a;
      expect_at(K_REG, 0, v, tag);
      @(negedge clk);
   endtask

   // monitor: compares each item in the cycle it is due
   always @(negedge clk) begin : mon
      int idx;
      logic [31:0] act;
      #1;
      idx = 0;
      while (idx < sb.size()) begin
         if (sb[idx].due == cyc) begin
            case (sb[idx].kind)
               K_IRQ:   act = {16'h0, irq};
               K_EVT:   act = {16'h0, evt};
               default: act = (reg_addr == sb[idx].addr) ? reg_rdata : 32'hDEAD_BEEF;
            endcase
            n_chk++;
            if (act !== sb[idx].exp) begin
               n_fail++;
               $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h",
                        sb[idx].tag, sb[idx].kind, sb[idx].addr, act, sb[idx].exp);
            end
            sb.delete(idx);
         end else begin
            idx++;
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(1);
      // R1: reset state
      expect_at(K_IRQ, 0, 0, "R1");
      expect_at(K_EVT, 0, 0, "R1");
      for (int a = 0; a < 9; a++) rd(4'(a), 0, "R1");

      // R2: select field placement, line4=0 line5=1 line6=2, line15=3
      wr(4'd1, 32'h0000_0210);
      wr(4'd3, 32'hFFFF_3000);
      rd(4'd1, 32'h0000_0210, "R2");
      rd(4'd3, 32'h0000_3000, "R2");
      rd(4'd0, 32'h0, "R2");

      wr(4'd6, 32'h20);
      wr(4'd4, 32'h20);
      wr(4'd5, 32'h20);
      rd(4'd6, 32'h20, "R2");

      // R3: port 0 bit 5 is not line 5's source
      pins[5] = 1'b1;
      expect_at(K_EVT, 2, 0, "R3");
      expect_at(K_IRQ, 3, 0, "R3");
      tick(4);
      rd(4'd8, 0, "R3");
      pins[5] = 1'b0;
      tick(4);

      // R4: rising edge on port 1 bit 5
      pins[21] = 1'b1;
      expect_at(K_EVT, 1, 0, "R4");
      expect_at(K_EVT, 2, 32'h20, "R4");
      expect_at(K_EVT, 3, 0, "R4");
      expect_at(K_IRQ, 2, 0, "R4");
      expect_at(K_IRQ, 3, 32'h20, "R4");
      tick(4);
      rd(4'd8, 32'h20, "R4");

      // R9: write 0 keeps, write 1 clears
      wr(4'd8, 32'h0);
      rd(4'd8, 32'h20, "R9");
      wr(4'd8, 32'h20);
      expect_at(K_IRQ, 0, 0, "R9");
      rd(4'd8, 0, "R9");

      // R5: fall ignored while disabled, then both edges
      pins[21] = 1'b0;
      expect_at(K_EVT, 2, 0, "R5");
      expect_at(K_IRQ, 3, 0, "R5");
      tick(4);
      wr(4'd7, 32'h20);
      pins[21] = 1'b1;
      expect_at(K_EVT, 2, 32'h20, "R5");
      tick(4);
      wr(4'd8, 32'h20);
      pins[21] = 1'b0;
      expect_at(K_EVT, 2, 32'h20, "R5");
      expect_at(K_IRQ, 3, 32'h20, "R5");
      tick(4);
      wr(4'd8, 32'h20);

      // R8 / R7: masked edge gives event but no pending
      wr(4'd4, 32'h0);
      pins[21] = 1'b1;
      expect_at(K_EVT, 2, 32'h20, "R7");
      expect_at(K_IRQ, 3, 0, "R8");
      tick(4);
      rd(4'd8, 0, "R7");
      wr(4'd4, 32'h20);
      pins[21] = 1'b0;
      expect_at(K_IRQ, 3, 32'h20, "R8");
      tick(4);
      wr(4'd4, 32'h0);
      expect_at(K_IRQ, 0, 0, "R8");
      rd(4'd8, 32'h20, "R8");
      wr(4'd4, 32'h20);
      expect_at(K_IRQ, 0, 32'h20, "R8");
      tick(1);
      wr(4'd8, 32'h20);

      // R7: event mask off
      wr(4'd5, 32'h0);
      pins[21] = 1'b1;
      expect_at(K_EVT, 2, 0, "R7");
      expect_at(K_IRQ, 3, 32'h20, "R7");
      tick(4);
      wr(4'd8, 32'h20);
      wr(4'd5, 32'h20);

      // R10: clear lands in the same cycle as the edge
      pins[21] = 1'b0;
      tick(2);
      wr(4'd8, 32'h20);
      expect_at(K_IRQ, 0, 32'h20, "R10");
      rd(4'd8, 32'h20, "R10");
      wr(4'd8, 32'h20);
      rd(4'd8, 0, "R10");

      // R6: line 6 masks on, no edge enables
      wr(4'd4, 32'h60);
      wr(4'd5, 32'h60);
      pins[38] = 1'b1;
      expect_at(K_EVT, 2, 0, "R6");
      expect_at(K_IRQ, 3, 0, "R6");
      tick(4);
      rd(4'd8, 0, "R6");
      pins[38] = 1'b0;
      tick(4);

      // R11: line 7 select 9 (no such port), line 15 on port 3
      wr(4'd1, 32'h0000_9210);
      wr(4'd6, 32'h80A0);
      wr(4'd4, 32'h80E0);
      wr(4'd5, 32'h80E0);
      rd(4'd1, 32'h0000_9210, "R2");
      pins[7] = 1'b1; pins[23] = 1'b1; pins[39] = 1'b1; pins[55] = 1'b1;
      pins[63] = 1'b1;
      expect_at(K_EVT, 2, 32'h8000, "R11");
      expect_at(K_IRQ, 3, 32'h8000, "R11");
      tick(4);
      rd(4'd8, 32'h8000, "R11");

      tick(2);
      if (sb.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard actual=%0d expected=0 items left", sb.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule